// File: doc/BRIEF.md
# Audio Activity Flag with Selectable Release Hold

This block turns two per-channel level-detector bits into one activity flag. Each detector bit is high while its channel's audio is louder than the detection threshold. The analog threshold and the high-pass filtering sit outside the block. The flag goes high a few clock cycles after either channel shows activity. It stays high for as long as activity lasts. After both channels go quiet, the flag holds high for a release interval and only then drops. A 3-bit select input chooses the interval in seconds. The flag is meant to feed a standby input, so a system parks itself after a long silence but not during short pauses between tracks.

Time is counted in pulses of a one-second tick input. A simulation can therefore speed up the release interval by pulsing the tick faster. Any activity that appears while the release countdown runs cancels the countdown and keeps the flag high. The full interval then starts again when silence returns. The select value is read only at the moment a countdown starts.

Top module: `audio_activity_flag`

## Requirements
- R1: While reset is asserted, and after it is released with no activity, `flag_o` is low.
- R2: When either detector input goes high, `flag_o` goes high on the third rising clock edge after the input change (SYNC_STAGES+1 edges with the default of 2) and not earlier.
- R3: While either detector input stays high, `flag_o` stays high.
- R4: With select code 0, `flag_o` goes low on the third rising edge after both detector inputs go low, with no tick needed.
- R5: With a nonzero select code k, the release interval is 60 ticks for k=1 and 60+30*(k-1) ticks otherwise (90, 120, 150, 180, 210, 240 for k=2..7). Counting starts three edges after both inputs go low. `flag_o` goes low on the clock edge that samples the last tick of the interval and stays high before it.
- R6: Activity on either input during a release countdown keeps `flag_o` high and discards the count, so the next quiet period needs the full interval again.
- R7: A change of the select input during a countdown does not change that countdown's length. The new value applies from the next countdown start.
- R8: Tick pulses that arrive while the flag is low, or while activity is present, have no effect: the flag stays low while idle, and a later countdown still needs its full interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| act_left_i | input | 1 | Left channel above threshold (asynchronous) |
| act_right_i | input | 1 | Right channel above threshold (asynchronous) |
| sec_tick_i | input | 1 | One-cycle pulse per second of release time |
| dly_sel_i | input | 3 | Release interval select code |
| flag_o | output | 1 | Activity flag, high while audio is present or the release hold runs |

## Verification
Assertions check several rules on every cycle:
- synchronized activity always leaves the flag high on the next cycle;
- the flag never drops on a cycle that followed synchronized activity;
- every rise of the flag is preceded by synchronized activity;
- a running countdown never holds zero;
- the countdown never moves unless a tick arrives.

Some behaviour only the bench scenarios can show, because it needs long stimulus sequences:
- the exact interval length for each select code;
- the restart of the full interval after activity interrupts a countdown;
- the rule that a select change reaches only the next countdown;
- the edge-accurate rise latency through the synchronizer.

// File: rtl/actflag_pkg.sv
package actflag_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_HOLD   = 2'd2
    } flag_state_e;

endpackage

// File: rtl/actflag_sync.sv
module actflag_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_left_i,
    input  logic act_right_i,
    output logic act_o
);
    logic raw;
    assign raw = act_left_i | act_right_i;

    generate
        if (STAGES == 0) begin : g_bypass
            assign act_o = raw;
        end else begin : g_chain
            logic [STAGES-1:0] chain_d, chain_q;

            always_comb begin
                chain_d[0] = raw;
                for (int i = 1; i < STAGES; i++) begin
                    chain_d[i] = chain_q[i-1];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= chain_d;
            end

            assign act_o = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/actflag_delay_map.sv
module actflag_delay_map #(
    parameter int SEL_W      = 3,
    parameter int CNT_W      = 8,
    parameter int BASE_TICKS = 60,
    parameter int STEP_TICKS = 30
) (
    input  logic [SEL_W-1:0] sel_i,
    output logic [CNT_W-1:0] ticks_o
);
    localparam int MAX_TICKS = BASE_TICKS + STEP_TICKS * ((1 << SEL_W) - 2);

    // Code 0 means an immediate release; others grow linearly from the base.
    always_comb begin
        if (sel_i == '0) ticks_o = '0;
        else             ticks_o = CNT_W'(BASE_TICKS + STEP_TICKS * (int'(sel_i) - 1));
    end

    initial begin
        if (MAX_TICKS >= (1 << CNT_W))
            $display("actflag_delay_map: CNT_W too narrow for %0d ticks", MAX_TICKS);
    end

endmodule

// File: rtl/actflag_ctrl.sv
module actflag_ctrl
    import actflag_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_s_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] dly_ticks_i,
    output logic             flag_o
);
    typedef struct packed {
        flag_state_e      st;
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } ctrl_t;

    ctrl_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (act_s_i) begin
                    r_d.st   = ST_ACTIVE;
                    r_d.flag = 1'b1;
                    r_d.cnt  = '0;
                end
            end
            ST_ACTIVE: begin
                if (!act_s_i) begin
                    if (dly_ticks_i == '0) begin
                        r_d.st   = ST_IDLE;
                        r_d.flag = 1'b0;
                    end else begin
                        r_d.st  = ST_HOLD;
                        r_d.cnt = dly_ticks_i;
                    end
                end
            end
            ST_HOLD: begin
                if (act_s_i) begin
                    r_d.st  = ST_ACTIVE;
                    r_d.cnt = '0;
                end else if (tick_i) begin
                    if (r_q.cnt == CNT_W'(1)) begin
                        r_d.st   = ST_IDLE;
                        r_d.flag = 1'b0;
                        r_d.cnt  = '0;
                    end else begin
                        r_d.cnt = r_q.cnt - CNT_W'(1);
                    end
                end
            end
            default: begin
                r_d.st   = ST_IDLE;
                r_d.flag = 1'b0;
                r_d.cnt  = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.cnt  <= '0;
            r_q.flag <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign flag_o = r_q.flag;

    logic             hold_q;
    logic [CNT_W-1:0] cnt_q;
    assign hold_q = (r_q.st == ST_HOLD);
    assign cnt_q  = r_q.cnt;

    // R3: synchronized activity always leaves the flag high
    p_act_keeps_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        act_s_i |=> flag_o);

    // R4: the flag only drops after a cycle of synchronized silence
    p_fall_after_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_o) |-> !$past(act_s_i));

    // R5: a running countdown never holds zero
    p_hold_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |-> (cnt_q != '0));

    // R7: without a tick the countdown is frozen, whatever the select does
    p_hold_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && !act_s_i && !tick_i) |=> (hold_q && $stable(cnt_q)));

    // R8: ticks while idle leave the flag low
    p_idle_stays_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && !act_s_i) |=> !flag_o);

endmodule

// File: rtl/audio_activity_flag.sv
module audio_activity_flag #(
    parameter int SYNC_STAGES = 2,
    parameter int SEL_W       = 3,
    parameter int CNT_W       = 8,
    parameter int BASE_TICKS  = 60,
    parameter int STEP_TICKS  = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_left_i,
    input  logic             act_right_i,
    input  logic             sec_tick_i,
    input  logic [SEL_W-1:0] dly_sel_i,
    output logic             flag_o
);
    logic             act_s;
    logic [CNT_W-1:0] dly_ticks;

    actflag_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_left_i (act_left_i),
        .act_right_i(act_right_i),
        .act_o      (act_s)
    );

    actflag_delay_map #(
        .SEL_W     (SEL_W),
        .CNT_W     (CNT_W),
        .BASE_TICKS(BASE_TICKS),
        .STEP_TICKS(STEP_TICKS)
    ) map_i (
        .sel_i  (dly_sel_i),
        .ticks_o(dly_ticks)
    );

    actflag_ctrl #(.CNT_W(CNT_W)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_s_i    (act_s),
        .tick_i     (sec_tick_i),
        .dly_ticks_i(dly_ticks),
        .flag_o     (flag_o)
    );

    // R2: every rise of the flag follows synchronized activity
    p_rise_follows_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(act_s));

endmodule

// File: tb/audio_activity_flag_tb_top.sv
`timescale 1ns/1ps
module audio_activity_flag_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       act_l = 1'b0;
    logic       act_r = 1'b0;
    logic       tick = 1'b0;
    logic [2:0] sel = 3'd0;
    logic       flag;

    int unsigned cyc = 0;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    typedef struct {
        int unsigned at;
        logic        val;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    audio_activity_flag dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_left_i (act_l),
        .act_right_i(act_r),
        .sec_tick_i (tick),
        .dly_sel_i  (sel),
        .flag_o     (flag)
    );

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_at(int unsigned at, logic v, string tag);
        exp_t e;
        e.at = at; e.val = v; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // monitor: compares expected items as their cycle comes up
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].at <= cyc) begin
            exp_t e;
            e = exp_q.pop_front();
            n_cmp++;
            if (e.at != cyc || flag !== e.val) begin
                n_bad++;
                $display("FAIL %s cycle %0d: flag=%b expected %b (due %0d)",
                         e.tag, cyc, flag, e.val, e.at);
            end
        end
    end

    function automatic int interval(logic [2:0] code);
        return (code == 3'd0) ? 0 : 60 + 30 * (int'(code) - 1);
    endfunction

    task automatic pulse_ticks(int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; step(1); tick = 1'b0; step(2);
        end
    endtask

    task automatic raise(logic l, logic r, string tag);
        int unsigned c;
        c = cyc;
        act_l = l; act_r = r;
        expect_at(c + 2, 1'b0, tag);
        expect_at(c + 3, 1'b1, tag);
        step(5);
    endtask

    task automatic run_quiet(logic [2:0] code, string tag);
        int unsigned c;
        int n;
        n = interval(code);
        sel = code;
        c = cyc;
        act_l = 1'b0; act_r = 1'b0;
        expect_at(c + 2, 1'b1, tag);
        if (n == 0) begin
            expect_at(c + 3, 1'b0, tag);
            step(5);
        end else begin
            step(6);
            pulse_ticks(n - 1);
            expect_at(cyc + 1, 1'b1, tag);
            step(2);
            tick = 1'b1;
            expect_at(cyc + 1, 1'b0, tag);
            step(1);
            tick = 1'b0;
            expect_at(cyc + 2, 1'b0, tag);
            step(3);
        end
    endtask

    initial begin
        // R1: reset state
        step(2);
        expect_at(cyc + 1, 1'b0, "R1");
        step(2);
        rst_n = 1'b1;
        expect_at(cyc + 2, 1'b0, "R1");
        step(4);

        // R2/R3/R4: right channel alone, immediate release
        raise(1'b0, 1'b1, "R2");
        expect_at(cyc + 4, 1'b1, "R3");
        step(6);
        run_quiet(3'd0, "R4");

        // R8: ticks while idle leave the flag low
        pulse_ticks(5);
        expect_at(cyc + 1, 1'b0, "R8");
        step(2);

        // R8: ticks during activity do not shorten the later countdown
        raise(1'b1, 1'b0, "R2");
        pulse_ticks(70);
        expect_at(cyc + 1, 1'b1, "R3");
        step(2);
        run_quiet(3'd1, "R8");

        // R5: longest interval, both channels
        raise(1'b1, 1'b1, "R2");
        run_quiet(3'd7, "R5");

        // R5: remaining codes
        for (int k = 4; k <= 6; k++) begin
            raise(1'b1, 1'b0, "R2");
            run_quiet(3'(k), "R5");
        end

        // R6: activity during countdown restarts the full interval
        raise(1'b0, 1'b1, "R2");
        sel = 3'd3;
        act_r = 1'b0;
        step(6);
        pulse_ticks(50);
        act_l = 1'b1;
        expect_at(cyc + 1, 1'b1, "R6");
        expect_at(cyc + 4, 1'b1, "R6");
        step(6);
        run_quiet(3'd3, "R6");

        // R7: select change mid-countdown ignored, used at next start
        raise(1'b1, 1'b0, "R2");
        sel = 3'd2;
        act_l = 1'b0;
        step(6);
        pulse_ticks(10);
        sel = 3'd0;
        pulse_ticks(79);
        expect_at(cyc + 1, 1'b1, "R7");
        step(2);
        tick = 1'b1;
        expect_at(cyc + 1, 1'b0, "R7");
        step(1);
        tick = 1'b0;
        step(3);
        raise(1'b1, 1'b0, "R2");
        run_quiet(3'd0, "R7");

        step(4);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // watchdog
    always @(posedge clk) begin
        if (!done && cyc > 150000) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: cycle=%0d expected completion before 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule